// File: doc/BRIEF.md
# Three-Wire Serial Word Loader

This block takes programming words for a frequency synthesiser over a three-wire serial link made of data, clock and enable lines. All three lines are slow next to the system clock. The block synchronises them into the system clock domain and finds their edges there. While enable is high, each rising serial clock shifts one data bit into a 24-bit shift register, most significant bit first.

When enable falls, the last two bits shifted decide where the first 22 bits of the frame go. The destination is one of two frequency words, a reference word, or a short path that rewrites only the A count of the active frequency word. Every holding register keeps driving the divider logic while a new frame is being shifted in. A frequency word can therefore be rewritten while the other one is in use, and a select input switches between the two at once.

The outputs are the decoded fields of the active frequency word and of the reference word. The frequency word supplies the A count, M count, pump gain and phase sense. The reference word supplies the reference ratio, the phase detector enable pair and the prescaler modulus flag.

Top module: `serial_word_loader`

## Requirements
- R1: While `ser_en` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 24-bit register, so the first bit sent ends up as the frame MSB (bit 23) after 24 shifts.
- R2: Rising edges of `ser_clk` while `ser_en` is low change nothing; a later enable pulse with no clocks transfers the register exactly as it was.
- R3: On a falling edge of `ser_en`, frame bits [1:0] form the code {C2,C1} (C2 = second-last bit sent): 00 loads F1, 01 loads F2, 10 is the A-only transfer, 11 loads the reference word; the payload is frame bits [23:2].
- R4: A frequency word is payload[3:0] A count, [18:4] M count, [20:19] pump gain, [21] phase sense.
- R5: The reference word is payload[12:0] ratio, [14:13] phase detector enables, [15] prescaler flag (1 = 8/9 pair, 0 = 16/17); payload[21:16] is ignored.
- R6: The A-only transfer writes payload[3:0] into the A count of the word selected at that moment, leaving every other field and the other words untouched.
- R7: Loading one holding register leaves the other two unchanged; without a transfer, no holding register changes.
- R8: With `sel_f1` high the outputs show F1; with it low they show F2.
- R9: After reset all fields read zero except `ref_ratio`, which reads 1.
- R10: A reference ratio loaded as 0 is stored as 1.
- R11: With the 8/9 prescaler flag set, `a_count[3]` reads 0 and only the low three A bits are passed on.
- R12: A transfer becomes visible on the outputs at the third system clock rising edge after `ser_en` falls, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial bit clock, sampled in the system domain |
| ser_en | input | 1 | Serial frame enable; falling edge commits the frame |
| sel_f1 | input | 1 | High selects F1, low selects F2 |
| a_count | output | 4 | A count of the active frequency word |
| m_count | output | 15 | M count of the active frequency word |
| cp_gain | output | 2 | Pump gain bits of the active frequency word |
| pd_sense | output | 1 | Phase detector sense of the active frequency word |
| ref_ratio | output | 13 | Reference division ratio (never 0) |
| pd_enable | output | 2 | Phase detector enable control |
| presc_8_9 | output | 1 | Prescaler modulus flag, 1 for 8/9 |

## Verification
A wrong code decode or a misplaced field shows up on the output fields three system clocks after enable falls. In the worst case it shows up only once the select input points at the word that was corrupted. The bench therefore flips the select after every pair of loads, so that damage to an inactive F1 or F2 word is seen within a few cycles and not left hidden. A shift register that wrongly moves while enable is low stays invisible until the next commit. The bench forces that commit straight away with a clockless enable pulse. A latency that is one edge off is caught by sampling both the second and the third edge after the fall.

// File: rtl/swl_pkg.sv
package swl_pkg;

    localparam int SR_W   = 24;
    localparam int CODE_W = 2;
    localparam int PAY_W  = SR_W - CODE_W;
    localparam int A_W    = 4;
    localparam int M_W    = 15;
    localparam int G_W    = 2;
    localparam int RR_W   = 13;
    localparam int PDE_W  = 2;
    localparam int FW_W   = A_W + M_W + G_W + 1;
    localparam int RW_W   = RR_W + PDE_W + 1;

    typedef struct packed {
        logic             sense;
        logic [G_W-1:0]   gain;
        logic [M_W-1:0]   m;
        logic [A_W-1:0]   a;
    } freq_word_t;

    typedef struct packed {
        logic             presc_89;
        logic [PDE_W-1:0] pd_en;
        logic [RR_W-1:0]  ratio;
    } ref_word_t;

    typedef enum logic [CODE_W-1:0] {
        DEST_F1    = 2'b00,
        DEST_F2    = 2'b01,
        DEST_ABITS = 2'b10,
        DEST_REF   = 2'b11
    } dest_e;

    localparam freq_word_t FREQ_RESET = '0;
    localparam ref_word_t  REF_RESET  = '{presc_89: 1'b0, pd_en: '0, ratio: RR_W'(1)};

    function automatic freq_word_t unpack_freq(input logic [PAY_W-1:0] p);
        return freq_word_t'(p[FW_W-1:0]);
    endfunction

    function automatic ref_word_t unpack_ref(input logic [PAY_W-1:0] p);
        ref_word_t r;
        r = ref_word_t'(p[RW_W-1:0]);
        if (r.ratio == '0) r.ratio = RR_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/swl_shreg.sv
module swl_shreg #(
    parameter int W = swl_pkg::SR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (shift) q <= {q[W-2:0], din};
    end

    a_r1_bit_enters_lsb: assert property (@(posedge clk) disable iff (rst)
        shift |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0])));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(q));
endmodule

// File: rtl/swl_bank.sv
module swl_bank
    import swl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer,
    input  dest_e            code,
    input  logic [PAY_W-1:0] payload,
    input  logic             sel_f1,
    output freq_word_t       active,
    output ref_word_t        refw
);
    freq_word_t f1_q, f2_q;
    ref_word_t  ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f1_q  <= FREQ_RESET;
            f2_q  <= FREQ_RESET;
            ref_q <= REF_RESET;
        end else if (xfer) begin
            unique case (code)
                DEST_F1:  f1_q  <= unpack_freq(payload);
                DEST_F2:  f2_q  <= unpack_freq(payload);
                DEST_REF: ref_q <= unpack_ref(payload);
                DEST_ABITS: begin
                    if (sel_f1) f1_q.a <= payload[A_W-1:0];
                    else        f2_q.a <= payload[A_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign active = sel_f1 ? f1_q : f2_q;
    assign refw   = ref_q;

    a_r7_hold_without_xfer: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(f1_q) && $stable(f2_q) && $stable(ref_q));

    a_r7_f1_load_spares_others: assert property (@(posedge clk) disable iff (rst)
        (xfer && code == DEST_F1) |=> $stable(f2_q) && $stable(ref_q));

    a_r7_f2_load_spares_others: assert property (@(posedge clk) disable iff (rst)
        (xfer && code == DEST_F2) |=> $stable(f1_q) && $stable(ref_q));

    a_r6_abits_keep_upper: assert property (@(posedge clk) disable iff (rst)
        (xfer && code == DEST_ABITS) |=> $stable(ref_q) && $stable(f1_q.m)
            && $stable(f2_q.m) && $stable(f1_q.gain) && $stable(f2_q.gain));

    a_r10_ratio_nonzero: assert property (@(posedge clk) disable iff (rst)
        ref_q.ratio != '0);
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
    import swl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             ser_en,
    input  logic             sel_f1,
    output logic [A_W-1:0]   a_count,
    output logic [M_W-1:0]   m_count,
    output logic [G_W-1:0]   cp_gain,
    output logic             pd_sense,
    output logic [RR_W-1:0]  ref_ratio,
    output logic [PDE_W-1:0] pd_enable,
    output logic             presc_8_9
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] sync_in, sync_out;
    logic data_s, sclk_s, en_s, sel_s;
    logic sclk_d, en_d;
    logic shift_pulse, xfer_pulse;
    logic [SR_W-1:0] sr_q;
    freq_word_t active;
    ref_word_t  refw;

    assign sync_in = {sel_f1, ser_en, ser_clk, ser_data};
    assign {sel_s, en_s, sclk_s, data_s} = sync_out;

    swl_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .dout (sync_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            en_d   <= en_s;
        end
    end

    assign shift_pulse = sclk_s & ~sclk_d & en_s;
    assign xfer_pulse  = ~en_s & en_d;

    swl_shreg #(.W(SR_W)) u_shreg (
        .clk   (clk),
        .rst   (rst),
        .shift (shift_pulse),
        .din   (data_s),
        .q     (sr_q)
    );

    swl_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .xfer    (xfer_pulse),
        .code    (dest_e'(sr_q[CODE_W-1:0])),
        .payload (sr_q[SR_W-1:CODE_W]),
        .sel_f1  (sel_s),
        .active  (active),
        .refw    (refw)
    );

    assign a_count   = refw.presc_89 ? {1'b0, active.a[A_W-2:0]} : active.a;
    assign m_count   = active.m;
    assign cp_gain   = active.gain;
    assign pd_sense  = active.sense;
    assign ref_ratio = refw.ratio;
    assign pd_enable = refw.pd_en;
    assign presc_8_9 = refw.presc_89;

    a_r11_three_bit_a: assert property (@(posedge clk) disable iff (rst)
        presc_8_9 |-> !a_count[A_W-1]);

    a_r2_no_shift_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> $stable(sr_q));

    a_r3_commit_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({shift_pulse, xfer_pulse}));
endmodule

// File: tb/test_serial_word_loader.sv
module test_serial_word_loader;
    localparam int SR_W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0, sel_f1 = 1'b1;
    logic [3:0]  a_count;
    logic [14:0] m_count;
    logic [1:0]  cp_gain;
    logic        pd_sense;
    logic [12:0] ref_ratio;
    logic [1:0]  pd_enable;
    logic        presc_8_9;

    int n_checks = 0;
    int n_fail   = 0;

    logic [21:0] ef1 = '0, ef2 = '0;
    logic [15:0] eref = 16'h0001;

    always #4 clk = ~clk;

    serial_word_loader i_serial_word_loader (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_en(ser_en), .sel_f1(sel_f1), .a_count(a_count), .m_count(m_count),
        .cp_gain(cp_gain), .pd_sense(pd_sense), .ref_ratio(ref_ratio),
        .pd_enable(pd_enable), .presc_8_9(presc_8_9)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [21:0] w;
        logic [3:0]  ea;
        w  = sel_f1 ? ef1 : ef2;
        ea = eref[15] ? {1'b0, w[2:0]} : w[3:0];
        chk(req, "a_count",   32'(a_count),   32'(ea));
        chk(req, "m_count",   32'(m_count),   32'(w[18:4]));
        chk(req, "cp_gain",   32'(cp_gain),   32'(w[20:19]));
        chk(req, "pd_sense",  32'(pd_sense),  32'(w[21]));
        chk(req, "ref_ratio", 32'(ref_ratio), 32'(eref[12:0]));
        chk(req, "pd_enable", 32'(pd_enable), 32'(eref[14:13]));
        chk(req, "presc_8_9", 32'(presc_8_9), 32'(eref[15]));
    endtask

    task automatic shift_frame(input logic [21:0] payload, input logic [1:0] code);
        logic [SR_W-1:0] frame;
        frame  = {payload, code};
        ser_en = 1'b1;
        wait_n(4);
        for (int i = SR_W - 1; i >= 0; i--) begin
            ser_data = frame[i];
            wait_n(4);
            ser_clk = 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic send(input logic [21:0] payload, input logic [1:0] code);
        shift_frame(payload, code);
        ser_en = 1'b0;
        wait_n(6);
    endtask

    function automatic logic [21:0] mk_freq(input int i);
        logic [14:0] m;
        m = 15'(i * 2731 + 77);
        return {1'(i), 2'(i >> 1), m, 4'(i)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        wait_n(5);
        rst = 1'b0;
        wait_n(4);
        check_all("R9");

        // R3 R4 R7 R8: sweep all A values through F1 while F2 is reloaded behind it
        for (int i = 0; i < 16; i++) begin
            sel_f1 = 1'b1;
            wait_n(4);
            send(mk_freq(i), 2'b00);
            ef1 = mk_freq(i);
            check_all("R4");
            send(mk_freq(i + 40) ^ 22'h2AAAAA, 2'b01);
            ef2 = mk_freq(i + 40) ^ 22'h2AAAAA;
            check_all("R7");
            sel_f1 = 1'b0;
            wait_n(4);
            check_all("R8");
        end

        // R12: visible at the third edge after the enable fall, not the second
        sel_f1 = 1'b1;
        wait_n(4);
        shift_frame(22'h155AA3, 2'b00);
        ser_en = 1'b0;
        wait_n(2);
        check_all("R12");
        wait_n(1);
        ef1 = 22'h155AA3;
        check_all("R12");
        wait_n(4);

        // R5 R10 R11: reference words, junk in payload[21:16]
        for (int j = 0; j < 8; j++) begin
            logic [12:0] r;
            logic [21:0] p;
            case (j)
                0: r = 13'd2;
                1: r = 13'd0;
                2: r = 13'd8191;
                3: r = 13'd4096;
                4: r = 13'h1555;
                5: r = 13'd0;
                6: r = 13'd3;
                default: r = 13'd1;
            endcase
            p = {6'h2A ^ 6'(j), 1'(j), 2'(j + 1), r};
            send(p, 2'b11);
            eref = {1'(j), 2'(j + 1), (r == 13'd0) ? 13'd1 : r};
            check_all((r == 13'd0) ? "R10" : "R5");
            if (j[0]) begin
                ef1 = {ef1[21:4], 4'hF};
                send({18'h3FFFF, 4'hF}, 2'b10);
                check_all("R11");
            end
        end

        // R6: A-only transfer goes to the selected word only
        sel_f1 = 1'b1;
        wait_n(4);
        send({18'h3C3C3, 4'h5}, 2'b10);
        ef1 = {ef1[21:4], 4'h5};
        check_all("R6");
        sel_f1 = 1'b0;
        wait_n(4);
        check_all("R6");
        send({18'h00001, 4'h9}, 2'b10);
        ef2 = {ef2[21:4], 4'h9};
        check_all("R6");
        sel_f1 = 1'b1;
        wait_n(4);
        check_all("R6");

        // R2: clock edges with enable low must not alter the register;
        // a clockless enable pulse recommits the previous A-only frame to F2
        sel_f1 = 1'b0;
        wait_n(4);
        ser_data = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ser_clk = 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
            wait_n(4);
        end
        ser_en = 1'b1;
        wait_n(6);
        ser_en = 1'b0;
        wait_n(6);
        check_all("R2");
        sel_f1 = 1'b1;
        wait_n(4);
        check_all("R2");

        // R1: MSB-first order, bit pattern with distinct ends
        send(22'h200001, 2'b00);
        ef1 = 22'h200001;
        check_all("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule